// File: doc/BRIEF.md
# SPI Flash Read Address Router

This block sits on the wires between one SPI host and two SPI flash devices, a main device and a secondary device. It passes the host clock and data-out lines straight through to both flashes and gates each flash's chip select by the operating mode. It also picks which flash's data-out line is returned to the host. The host pins are sampled into the system clock domain through a short synchronizer. A small state machine follows each transaction: it takes the first 8 bits as a command, then 24 address bits, most significant bit first, sampled on rising SCLK (SPI mode 0).

In the shared mode, a read command (0x03 or 0x0B) followed by an address is checked against two programmable inclusive ranges. Each range has its own enable bit and its own target flash. Range 0 wins when both ranges match. With no match, a disabled range, or any other command, the main flash answers. The decision is taken when the last address bit is sampled and holds until chip select rises.

The state machine has five states. IDLE waits for chip select low and then goes to CMD. CMD goes to ADDR once the eighth bit has been sampled, if that bit completes a read command. Otherwise it goes to PASS. ADDR goes to ROUTED once the 24th address bit has been sampled, and the routing choice is latched on that transition. ROUTED and PASS hold until the end of the frame. Every state returns to IDLE when chip select is high, which also clears the routing choice.

Top module: `spi_read_router`

## Requirements
- R1: Host SCLK and MOSI reach both flashes unchanged. The chip select of each flash follows the host's by mode: mode 00 and 11 enable only the main flash, 01 only the secondary flash, and 10 (shared) both. A disabled flash chip select stays high.
- R2: In mode 00 and in the reserved mode 11, host MISO comes from the main flash. In mode 01 it comes from the secondary flash, whatever the command or address.
- R3: Control field layout is [1:0] mode, [2] range 0 enable, [3] range 1 enable, [4] range 0 target, [5] range 1 target, where a target of 1 means secondary. In mode 10, a command 0x03 or 0x0B followed by a 24-bit address inside an enabled range routes host MISO to that range's target.
- R4: Range bounds are inclusive: an address equal to the start or to the end matches, and one just outside either bound does not.
- R5: When both enabled ranges contain the address, range 0's target is used.
- R6: A disabled range never matches. A read whose address matches no enabled range is answered by the main flash.
- R7: Any command other than 0x03 or 0x0B, including the write command 0x02, leaves host MISO on the main flash, even when the address bytes that follow fall inside a range.
- R8: Before the last address bit is sampled, host MISO comes from the main flash. The latched choice holds until chip select rises, after which host MISO returns to the main flash and the next frame decodes afresh.
- R9: After reset the machine is in IDLE and host MISO comes from the main flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the host pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sclk | input | 1 | Host SPI clock |
| host_cs_n | input | 1 | Host chip select, active low |
| host_mosi | input | 1 | Host data out |
| host_miso | output | 1 | Data returned to the host |
| cfg_ctrl | input | 6 | Mode, range enables and range targets |
| cfg_r0_start | input | ADDR_W | Range 0 lowest address |
| cfg_r0_end | input | ADDR_W | Range 0 highest address |
| cfg_r1_start | input | ADDR_W | Range 1 lowest address |
| cfg_r1_end | input | ADDR_W | Range 1 highest address |
| main_flash_sclk | output | 1 | Clock to the main flash |
| main_flash_cs_n | output | 1 | Chip select to the main flash |
| main_flash_mosi | output | 1 | Data to the main flash |
| main_flash_miso | input | 1 | Data from the main flash |
| sec_flash_sclk | output | 1 | Clock to the secondary flash |
| sec_flash_cs_n | output | 1 | Chip select to the secondary flash |
| sec_flash_mosi | output | 1 | Data to the secondary flash |
| sec_flash_miso | input | 1 | Data from the secondary flash |

## Verification
The bench uses the default parameters: a 24-bit address and a two-stage synchronizer. With these, real command and address frames can be sent bit by bit and routed at full address width, including bounds at 0x000000 and 0xFFFFFF. The host SCLK runs at one twelfth of the system clock, so the synchronizer latency stays well inside a half period, and results are sampled in the low phase after the last address edge. The two flash data lines are held at opposite constant levels, so the level seen on host MISO shows which flash was chosen.

// File: rtl/spi_rtr_pkg.sv
package spi_rtr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_ADDR   = 3'd2,
        ST_ROUTED = 3'd3,
        ST_PASS   = 3'd4
    } rtr_state_t;

    typedef enum logic [1:0] {
        MODE_MAIN  = 2'b00,
        MODE_SEC   = 2'b01,
        MODE_SHARE = 2'b10,
        MODE_RSVD  = 2'b11
    } rtr_mode_t;

    localparam int          CMD_W     = 8;
    localparam logic [7:0]  OP_READ   = 8'h03;
    localparam logic [7:0]  OP_FREAD  = 8'h0B;
    localparam int          NUM_RANGE = 2;

endpackage

// File: rtl/spi_rtr_sync.sv
module spi_rtr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= rst_val;
                end else begin
                    if (g == 0) pipe[g] <= d;
                    else        pipe[g] <= pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rtr_range.sv
module spi_rtr_range #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              en,
    output logic              hit
);
    always_comb begin
        hit = en && (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/spi_rtr_fsm.sv
module spi_rtr_fsm
    import spi_rtr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_q,
    input  logic              rise,
    input  logic              mosi_q,
    input  logic              want_sec,
    output logic [ADDR_W-1:0] addr_cand,
    output logic              route_sec,
    output rtr_state_t        state
);
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);

    rtr_state_t        state_n;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] shreg;
    logic [CMD_W-1:0]  cmd_cand;
    logic              is_read;

    assign addr_cand = {shreg[ADDR_W-2:0], mosi_q};
    assign cmd_cand  = {shreg[CMD_W-2:0], mosi_q};
    assign is_read   = (cmd_cand == OP_READ) || (cmd_cand == OP_FREAD);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (!cs_q) state_n = ST_CMD;
            ST_CMD:    if (rise && cnt == CMD_LAST)
                           state_n = is_read ? ST_ADDR : ST_PASS;
            ST_ADDR:   if (rise && cnt == ADDR_LAST) state_n = ST_ROUTED;
            ST_ROUTED: state_n = ST_ROUTED;
            ST_PASS:   state_n = ST_PASS;
            default:   state_n = ST_IDLE;
        endcase
        if (cs_q) state_n = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            route_sec <= 1'b0;
        end else begin
            if (state != state_n)                        cnt <= '0;
            else if (rise && (state == ST_CMD || state == ST_ADDR)) cnt <= cnt + 1'b1;

            if (rise && (state == ST_CMD || state == ST_ADDR))
                shreg <= addr_cand;

            if (state == ST_ADDR && state_n == ST_ROUTED) route_sec <= want_sec;
            else if (state_n == ST_IDLE)                  route_sec <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_read_router.sv
module spi_read_router
    import spi_rtr_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_cs_n,
    input  logic              host_mosi,
    output logic              host_miso,
    input  logic [5:0]        cfg_ctrl,
    input  logic [ADDR_W-1:0] cfg_r0_start,
    input  logic [ADDR_W-1:0] cfg_r0_end,
    input  logic [ADDR_W-1:0] cfg_r1_start,
    input  logic [ADDR_W-1:0] cfg_r1_end,
    output logic              main_flash_sclk,
    output logic              main_flash_cs_n,
    output logic              main_flash_mosi,
    input  logic              main_flash_miso,
    output logic              sec_flash_sclk,
    output logic              sec_flash_cs_n,
    output logic              sec_flash_mosi,
    input  logic              sec_flash_miso
);
    rtr_mode_t          mode;
    logic [2:0]         pins_q;
    logic               sclk_q, cs_q, mosi_q, sclk_d, rise;
    logic [ADDR_W-1:0]  addr_cand;
    logic [ADDR_W-1:0]  r_lo [NUM_RANGE];
    logic [ADDR_W-1:0]  r_hi [NUM_RANGE];
    logic [NUM_RANGE-1:0] hit;
    logic               want_sec, route_sec;
    rtr_state_t         st;

    assign mode = rtr_mode_t'(cfg_ctrl[1:0]);

    spi_rtr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(3'b010),
        .d({host_sclk, host_cs_n, host_mosi}), .q(pins_q)
    );
    assign {sclk_q, cs_q, mosi_q} = pins_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_q;
    end
    assign rise = sclk_q && !sclk_d;

    assign r_lo[0] = cfg_r0_start;
    assign r_hi[0] = cfg_r0_end;
    assign r_lo[1] = cfg_r1_start;
    assign r_hi[1] = cfg_r1_end;

    genvar g;
    generate
        for (g = 0; g < NUM_RANGE; g++) begin : g_rng
            spi_rtr_range #(.ADDR_W(ADDR_W)) u_rng (
                .addr(addr_cand), .lo(r_lo[g]), .hi(r_hi[g]),
                .en(cfg_ctrl[2+g]), .hit(hit[g])
            );
        end
    endgenerate

    always_comb begin
        if (hit[0])      want_sec = cfg_ctrl[4];
        else if (hit[1]) want_sec = cfg_ctrl[5];
        else             want_sec = 1'b0;
    end

    spi_rtr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .rise(rise), .mosi_q(mosi_q),
        .want_sec(want_sec), .addr_cand(addr_cand), .route_sec(route_sec),
        .state(st)
    );

    assign main_flash_sclk = host_sclk;
    assign main_flash_mosi = host_mosi;
    assign sec_flash_sclk  = host_sclk;
    assign sec_flash_mosi  = host_mosi;

    always_comb begin
        unique case (mode)
            MODE_SEC: begin
                main_flash_cs_n = 1'b1;
                sec_flash_cs_n  = host_cs_n;
                host_miso       = sec_flash_miso;
            end
            MODE_SHARE: begin
                main_flash_cs_n = host_cs_n;
                sec_flash_cs_n  = host_cs_n;
                host_miso       = route_sec ? sec_flash_miso : main_flash_miso;
            end
            MODE_MAIN, MODE_RSVD: begin
                main_flash_cs_n = host_cs_n;
                sec_flash_cs_n  = 1'b1;
                host_miso       = main_flash_miso;
            end
        endcase
    end
endmodule

// File: rtl/spi_rtr_chk.sv
module spi_rtr_chk
    import spi_rtr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_q,
    input rtr_state_t st,
    input logic       route_sec,
    input logic [5:0] cfg_ctrl,
    input logic       host_cs_n,
    input logic       main_flash_cs_n,
    input logic       sec_flash_cs_n
);
    // R8
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sec && !cs_q) |=> route_sec);

    // R8
    frame_end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> (st == ST_IDLE && !route_sec));

    // R3
    route_only_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_sec |-> st == ST_ROUTED);

    // R7
    pass_stays_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS) |-> !route_sec);

    // R1
    sec_mode_main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[1:0] == 2'b01) |-> main_flash_cs_n);

    // R1
    share_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctrl[1:0] == 2'b10 && !host_cs_n) |-> (!main_flash_cs_n && !sec_flash_cs_n));
endmodule

bind spi_read_router spi_rtr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .st(st), .route_sec(route_sec),
    .cfg_ctrl(cfg_ctrl), .host_cs_n(host_cs_n),
    .main_flash_cs_n(main_flash_cs_n), .sec_flash_cs_n(sec_flash_cs_n)
);

// File: tb/sim_spi_read_router.sv
`timescale 1ns/1ps
module sim_spi_read_router;
    localparam int AW = 24;
    localparam int H  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sclk = 1'b0, host_cs_n = 1'b1, host_mosi = 1'b0;
    logic host_miso;
    logic [5:0] cfg_ctrl = 6'h00;
    logic [AW-1:0] r0s = '0, r0e = '1, r1s = '0, r1e = '1;
    logic m_sclk, m_cs, m_mosi, s_sclk, s_cs, s_mosi;
    logic m_miso = 1'b0, s_miso = 1'b1;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    spi_read_router #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .host_cs_n(host_cs_n),
        .host_mosi(host_mosi), .host_miso(host_miso), .cfg_ctrl(cfg_ctrl),
        .cfg_r0_start(r0s), .cfg_r0_end(r0e), .cfg_r1_start(r1s), .cfg_r1_end(r1e),
        .main_flash_sclk(m_sclk), .main_flash_cs_n(m_cs), .main_flash_mosi(m_mosi),
        .main_flash_miso(m_miso), .sec_flash_sclk(s_sclk), .sec_flash_cs_n(s_cs),
        .sec_flash_mosi(s_mosi), .sec_flash_miso(s_miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b);
        host_mosi = b;
        repeat (H) @(negedge clk);
        host_sclk = 1'b1;
        repeat (H) @(negedge clk);
        host_sclk = 1'b0;
    endtask

    // full frame: command, address, check before and after the last bit, end, check return
    task automatic frame(input string req, input logic [7:0] cmd, input logic [23:0] addr,
                         input logic exp);
        @(negedge clk);
        host_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--) spi_bit(cmd[i]);
        for (int i = 23; i >= 1; i--) spi_bit(addr[i]);
        repeat (H) @(negedge clk);
        chk({req, " R8 before last bit"}, host_miso, (cfg_ctrl[1:0] == 2'b01) ? 1 : 0);
        spi_bit(addr[0]);
        repeat (H) @(negedge clk);
        chk(req, host_miso, exp);
        repeat (2*H) @(negedge clk);
        chk({req, " R8 held"}, host_miso, exp);
        host_cs_n = 1'b1;
        repeat (2*H) @(negedge clk);
        chk({req, " R8 after cs rise"}, host_miso, (cfg_ctrl[1:0] == 2'b01) ? 1 : 0);
    endtask

    task automatic t_reset;
        chk("R9 reset miso main", host_miso, 0);
        chk("R9 reset main cs follows", m_cs, 1);
    endtask

    task automatic t_gating;
        logic [1:0] md;
        for (int k = 0; k < 4; k++) begin
            md = 2'(k);
            cfg_ctrl = {4'b0000, md};
            @(negedge clk);
            host_cs_n = 1'b0;
            #2;
            chk("R1 main cs", m_cs, (md == 2'b01) ? 1 : 0);
            chk("R1 sec cs", s_cs, (md == 2'b01 || md == 2'b10) ? 0 : 1);
            chk("R2 miso by mode", host_miso, (md == 2'b01) ? 1 : 0);
            host_sclk = 1'b1; host_mosi = 1'b1;
            #2;
            chk("R1 sclk fwd", {m_sclk, s_sclk, m_mosi, s_mosi}, 4'b1111);
            host_sclk = 1'b0; host_mosi = 1'b0;
            #2;
            chk("R1 sclk low fwd", {m_sclk, s_sclk, m_mosi, s_mosi}, 4'b0000);
            host_cs_n = 1'b1;
            #2;
            chk("R1 cs released", {m_cs, s_cs}, 2'b11);
            repeat (2*H) @(negedge clk);
        end
    endtask

    task automatic t_split;
        r0s = 24'h000000; r0e = 24'h7FFFFF; r1s = 24'h800000; r1e = 24'hFFFFFF;
        cfg_ctrl = 6'h2E;
        frame("R3 read upper half", 8'h03, 24'h800000, 1);
        frame("R3 read lower half", 8'h03, 24'h7FFFFF, 0);
        frame("R3 fast read top", 8'h0B, 24'hFFFFFF, 1);
        frame("R7 write stays main", 8'h02, 24'h900000, 0);
        frame("R7 other cmd stays main", 8'h9F, 24'hC00000, 0);
    endtask

    task automatic t_bounds;
        r1s = 24'h100000; r1e = 24'h1000FF;
        cfg_ctrl = 6'h2A;
        frame("R4 start inclusive", 8'h03, 24'h100000, 1);
        frame("R4 end inclusive", 8'h03, 24'h1000FF, 1);
        frame("R4 below start", 8'h03, 24'h0FFFFF, 0);
        frame("R4 above end", 8'h03, 24'h100100, 0);
    endtask

    task automatic t_priority;
        r0s = 24'h100000; r0e = 24'h1FFFFF; r1s = 24'h000000; r1e = 24'hFFFFFF;
        cfg_ctrl = 6'h2E;
        frame("R5 range0 wins main", 8'h03, 24'h150000, 0);
        frame("R5 only range1 sec", 8'h03, 24'h250000, 1);
        cfg_ctrl = 6'h1E;
        frame("R5 range0 wins sec", 8'h0B, 24'h150000, 1);
    endtask

    task automatic t_disabled;
        r0s = 24'h000000; r0e = 24'hFFFFFF; r1s = 24'h000000; r1e = 24'hFFFFFF;
        cfg_ctrl = 6'h32;
        frame("R6 both disabled", 8'h03, 24'h123456, 0);
        r1s = 24'h400000; r1e = 24'h4FFFFF;
        cfg_ctrl = 6'h2A;
        frame("R6 no match", 8'h03, 24'h500000, 0);
    endtask

    task automatic t_modes;
        r1s = 24'h000000; r1e = 24'hFFFFFF;
        cfg_ctrl = 6'h2B;
        frame("R2 reserved mode main", 8'h03, 24'h010203, 0);
        cfg_ctrl = 6'h28;
        frame("R2 main mode", 8'h03, 24'h010203, 0);
        cfg_ctrl = 6'h09;
        frame("R2 secondary mode", 8'h03, 24'h010203, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_gating();
        t_split();
        t_bounds();
        t_priority();
        t_disabled();
        t_modes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule